// File: doc/BRIEF.md
# System Clock Source Selector and Machine-Cycle Divider

This block generates the clock enables for an 8051-style microcontroller core. It runs from one fast reference clock and produces two enables instead of separate clocks. The system-clock enable is the time base for the timers and peripherals. The machine-cycle enable is the time base for the CPU and fires on every fourth system-clock enable. A 2-bit source field picks one of three sources: the raw oscillator rate, a frequency-multiplied rate, or a very slow rate that is the oscillator divided by 256. A factor bit chooses between ×2 and ×4 on the multiplied path.

The reference clock runs at four times the oscillator rate. One oscillator tick is therefore one reference cycle in four. The ×2 rate gives an enable every second reference cycle, and the ×4 rate gives an enable on every reference cycle. A source change requested on the inputs is applied only where one machine cycle ends and the next begins. A machine cycle is therefore never built from enables of two different rates.

Top module: `clk_src_sel_div`

## Requirements
- R1: While reset is held, both enables are low. After reset the raw oscillator source is active, and the first system enable comes on the third rising reference edge after release.
- R2: With the source field at 2'b10, the system enable is high for one reference cycle in every 4.
- R3: The source field value 2'b01 gives the same behaviour as 2'b10, one system enable every 4 reference cycles.
- R4: With the source field at 2'b00 and the factor bit at 0, the system enable fires every 2 reference cycles.
- R5: With the source field at 2'b00 and the factor bit at 1, the system enable is high on every reference cycle.
- R6: With the source field at 2'b11, successive system enables are 1024 reference cycles apart (256 oscillator ticks).
- R7: The machine-cycle enable fires only together with a system enable, on every fourth system enable. Two machine-cycle pulses are therefore 4 system enables apart.
- R8: A change of the source field or the factor bit is applied only after the next machine-cycle enable. The system enables still due in the current machine cycle keep the old spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock, 4× the oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_field | input | 2 | Source select: 00 multiplied, 01/10 raw oscillator, 11 divide-by-256 |
| mul_x4 | input | 1 | Multiplier factor: 0 gives ×2, 1 gives ×4 |
| sys_en | output | 1 | System-clock enable, one reference cycle wide |
| mcyc_en | output | 1 | Machine-cycle enable, on every fourth system enable |

## Verification
The bench measures the spacing between enables in each source setting. A wrong decode of the reserved code, or a ×2/×4 swap, shows up directly as a spacing of 2 or 1 where 4 was expected. The divide-by-256 path is measured over two full periods, so an off-by-one wrap (1020 or 1028 cycles) is caught. The bench also changes the source in the middle of a machine cycle. A design that applied the change at once would show a shortened spacing before the machine-cycle enable instead of three more gaps at the old rate. The reset test catches a design that leaves the reset state with a pending enable or on the wrong source.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

   typedef enum logic [1:0] {
      SRC_OSC  = 2'd0,
      SRC_MUL2 = 2'd1,
      SRC_MUL4 = 2'd2,
      SRC_SLOW = 2'd3
   } src_e;

   // Map the source field and factor bit onto an active source.
   function automatic src_e decode_src(input logic [1:0] field, input logic x4);
      case (field)
         2'b00:   return x4 ? SRC_MUL4 : SRC_MUL2;
         2'b11:   return SRC_SLOW;
         default: return SRC_OSC;
      endcase
   endfunction

endpackage

// File: rtl/clk_ref_prescale.sv
module clk_ref_prescale #(
   parameter int REF_RATIO = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic osc_tick,
   output logic mul2_tick,
   output logic mul4_tick
);
   localparam int CW = $clog2(REF_RATIO);

   generate
      if (REF_RATIO < 4 || (1 << CW) != REF_RATIO) begin : g_bad_ratio
         $error("REF_RATIO must be a power of two and at least 4");
      end
   endgenerate

   logic [CW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= '0;
      else        phase_q <= phase_q + 1'b1;
   end

   assign osc_tick  = &phase_q;
   assign mul2_tick = &phase_q[CW-2:0];

   generate
      if (CW == 2) begin : g_mul4_every
         assign mul4_tick = 1'b1;
      end else begin : g_mul4_cmp
         assign mul4_tick = &phase_q[CW-3:0];
      end
   endgenerate

   AST_OSC_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      osc_tick |=> !osc_tick);  // R2

   AST_MUL2_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
      mul2_tick |=> !mul2_tick); // R4

endmodule

// File: rtl/clk_slow_div.sv
module clk_slow_div #(
   parameter int SLOW_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   output logic slow_tick
);
   generate
      if (SLOW_W < 1) begin : g_bad_width
         $error("SLOW_W must be at least 1");
      end
   endgenerate

   logic [SLOW_W-1:0] tick_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tick_cnt_q <= '0;
      else if (osc_tick) tick_cnt_q <= tick_cnt_q + 1'b1;
   end

   assign slow_tick = osc_tick & (&tick_cnt_q);

   AST_SLOW_ON_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      slow_tick |-> osc_tick);   // R6

   AST_SLOW_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      slow_tick |=> (tick_cnt_q == '0)); // R6

endmodule

// File: rtl/clk_mcyc_div.sv
module clk_mcyc_div
   import clk_src_pkg::*;
#(
   parameter int MCYC_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sys_en,
   input  src_e req_src,
   output logic mcyc_en,
   output src_e act_src
);
   localparam int MW = (MCYC_DIV > 1) ? $clog2(MCYC_DIV) : 1;
   localparam logic [MW-1:0] LAST = MW'(MCYC_DIV - 1);

   generate
      if (MCYC_DIV < 2) begin : g_bad_div
         $error("MCYC_DIV must be at least 2");
      end
   endgenerate

   logic [MW-1:0] sys_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_cnt_q <= '0;
      end else if (sys_en) begin
         sys_cnt_q <= (sys_cnt_q == LAST) ? '0 : sys_cnt_q + 1'b1;
      end
   end

   assign mcyc_en = sys_en && (sys_cnt_q == LAST);

   // Source only switches at a machine-cycle boundary.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       act_src <= SRC_OSC;
      else if (mcyc_en) act_src <= req_src;
   end

   AST_MCYC_WITH_SYS: assert property (@(posedge clk) disable iff (!rst_n)
      mcyc_en |-> sys_en);       // R7

   AST_MCYC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mcyc_en |=> !mcyc_en);     // R7

   AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !mcyc_en |=> $stable(act_src)); // R8

endmodule

// File: rtl/clk_src_sel_div.sv
module clk_src_sel_div
   import clk_src_pkg::*;
#(
   parameter int REF_RATIO = 4,
   parameter int SLOW_W    = 8,
   parameter int MCYC_DIV  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] src_field,
   input  logic       mul_x4,
   output logic       sys_en,
   output logic       mcyc_en
);
   logic osc_tick, mul2_tick, mul4_tick, slow_tick;
   src_e req_src, act_src;

   clk_ref_prescale #(.REF_RATIO(REF_RATIO)) i_prescale (
      .clk       (clk),
      .rst_n     (rst_n),
      .osc_tick  (osc_tick),
      .mul2_tick (mul2_tick),
      .mul4_tick (mul4_tick)
   );

   clk_slow_div #(.SLOW_W(SLOW_W)) i_slow (
      .clk       (clk),
      .rst_n     (rst_n),
      .osc_tick  (osc_tick),
      .slow_tick (slow_tick)
   );

   assign req_src = decode_src(src_field, mul_x4);

   always_comb begin
      unique case (act_src)
         SRC_MUL2: sys_en = mul2_tick;
         SRC_MUL4: sys_en = mul4_tick;
         SRC_SLOW: sys_en = slow_tick;
         default:  sys_en = osc_tick;
      endcase
   end

   clk_mcyc_div #(.MCYC_DIV(MCYC_DIV)) i_mcyc (
      .clk     (clk),
      .rst_n   (rst_n),
      .sys_en  (sys_en),
      .req_src (req_src),
      .mcyc_en (mcyc_en),
      .act_src (act_src)
   );

   AST_MUL4_DENSE: assert property (@(posedge clk) disable iff (!rst_n)
      (act_src == SRC_MUL4) |-> sys_en); // R5

   AST_OSC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (act_src == SRC_OSC && sys_en) |-> osc_tick); // R2

endmodule

// File: tb/test_clk_src_sel_div.sv
module test_clk_src_sel_div;
   localparam int CLK_PER = 10;
   localparam int GAP_LIMIT = 5000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] src_field = 2'b10;
   logic       mul_x4 = 1'b0;
   logic       sys_en, mcyc_en;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PER/2) clk = ~clk;

   clk_src_sel_div i_clk_src_sel_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_field (src_field),
      .mul_x4    (mul_x4),
      .sys_en    (sys_en),
      .mcyc_en   (mcyc_en)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Advance to the next sampled system enable; gap in reference cycles.
   task automatic next_sys(output int gap, output bit mc);
      gap = 0;
      do begin
         @(posedge clk); #1;
         gap++;
      end while (!sys_en && gap < GAP_LIMIT);
      mc = mcyc_en;
      if (gap >= GAP_LIMIT) chk("R6", "enable timeout", gap, -1);
   endtask

   task automatic wait_mcyc();
      int g; bit mc;
      do next_sys(g, mc); while (!mc);
   endtask

   // Apply a source, pass the boundary and settle one enable.
   task automatic switch_to(input logic [1:0] f, input logic x4);
      int g; bit mc;
      src_field = f; mul_x4 = x4;
      wait_mcyc();
      next_sys(g, mc);
   endtask

   task automatic measure_mcyc(input string req, input int exp_cycles);
      int g; bit mc; int cyc; int nsys;
      wait_mcyc();
      cyc = 0; nsys = 0;
      do begin next_sys(g, mc); cyc += g; nsys++; end while (!mc);
      chk(req, "mcyc spacing cycles", cyc, exp_cycles);
      chk("R7", "sys enables per mcyc", nsys, 4);
   endtask

   task automatic t_reset();
      int g; bit mc; int nsys;
      rst_n = 1'b0; src_field = 2'b10; mul_x4 = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "sys_en in reset", int'(sys_en), 0);
      chk("R1", "mcyc_en in reset", int'(mcyc_en), 0);
      rst_n = 1'b1;
      next_sys(g, mc);
      chk("R1", "first gap after reset", g, 3);
      nsys = 1;
      while (!mc) begin next_sys(g, mc); nsys++; chk("R1", "raw gap after reset", g, 4); end
      chk("R1", "sys enables to first mcyc", nsys, 4);
   endtask

   task automatic t_rate(input string req, input logic [1:0] f, input logic x4, input int exp_gap);
      int g; bit mc;
      switch_to(f, x4);
      for (int i = 0; i < 3; i++) begin
         next_sys(g, mc);
         chk(req, "sys gap", g, exp_gap);
      end
      measure_mcyc(req, exp_gap * 4);
   endtask

   task automatic t_boundary();
      int g; bit mc;
      switch_to(2'b10, 1'b0);
      wait_mcyc();
      next_sys(g, mc);               // first enable of a fresh machine cycle
      src_field = 2'b00; mul_x4 = 1'b1;
      for (int i = 0; i < 3; i++) begin
         next_sys(g, mc);
         chk("R8", "old rate held mid cycle", g, 4);
      end
      chk("R8", "change waits for mcyc", int'(mc), 1);
      next_sys(g, mc);
      chk("R8", "new rate after boundary", g, 1);
      // factor bit alone also waits for the boundary
      mul_x4 = 1'b0;
      next_sys(g, mc);
      chk("R8", "x4 kept until boundary", g, 1);
   endtask

   task automatic t_slow();
      int g; bit mc;
      switch_to(2'b11, 1'b0);
      for (int i = 0; i < 2; i++) begin
         next_sys(g, mc);
         chk("R6", "slow sys gap", g, 1024);
      end
   endtask

   initial begin
      #(CLK_PER * 200000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      t_reset();
      t_rate("R2", 2'b10, 1'b0, 4);
      t_rate("R3", 2'b01, 1'b1, 4);
      t_rate("R4", 2'b00, 1'b0, 2);
      t_rate("R5", 2'b00, 1'b1, 1);
      t_boundary();
      t_slow();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule